// File: doc/BRIEF.md
# Narrow External Bus Access Sequencer

This block connects an internal 32-bit bus master to external memory split into chip-select blocks. Each block has its own data bus width. The master issues one byte, half-word or word request at a time, as a read or a write, and names the target block. When the target block is 8 bits wide, the sequencer breaks the request into consecutive byte cycles on the low eight data lines, least significant byte first. For reads it collects the returned bytes back into their byte lanes. When the target block is wide, the request goes out as one full-width cycle with per-lane write enables.

Every external cycle holds its strobe for a fixed number of clocks. That number comes from a 4-bit wait value for each block, and no ready signal is sampled from the memory. Between two byte cycles of one request the strobes go inactive for one clock. Address and data use separate pins. Address, chip selects and strobes are all decoded from registers clocked by the single fast internal clock. When the last cycle is over, a one-cycle completion pulse appears with the assembled read word.

Top module: `narrow_bus_seq`

## Requirements
- R1: A byte request to an 8-bit block makes exactly one external cycle. That cycle uses the request's own address bits [1:0]. A write drives request data lane addr[1:0] on ext_d_out[7:0]. A read places the returned ext_d_in[7:0] in lane addr[1:0] of rdata, and the other lanes read 0.
- R2: A half-word request to an 8-bit block makes two cycles. Address bit 0 is 0 in the first and 1 in the second, and address bit 1 comes from the request. Each cycle carries the lane equal to its address bits [1:0].
- R3: A word request to an 8-bit block makes four cycles with address bits [1:0] = 00, 01, 10, 11 in that order. Cycle k carries lane k.
- R4: Block 0 is 8 bits wide when blk0_narrow = 1. Block b (b >= 1) is 8 bits wide when cfg_width[b] = 0. A request to a wide block makes one cycle on the request address. A write drives all 32 data lines with req_wdata, and ext_we_n is low for these lanes: lane addr[1:0] for a byte, lanes {addr[1],0} and {addr[1],1} for a half-word, and all four for a word. A read returns all 32 bits of ext_d_in.
- R5: Every external cycle holds its strobe low for exactly W+1 clocks, where W = cfg_wait[4b+3:4b] of the addressed block b.
- R6: Between two cycles of one request all strobes are high for exactly one clock. done is a one-clock pulse in the (N*(W+2))-th clock after the accepting edge, where N is the number of cycles. rdata is valid while done is high.
- R7: During a write cycle, ext_we_n is active (bit 0 alone on an 8-bit block), ext_d_oe = 1 and ext_re_n = 1. During a read cycle, ext_re_n = 0, ext_we_n = 4'hF and ext_d_oe = 0.
- R8: During a cycle, exactly the chip select of the addressed block is low (ext_cs_n bit b), and all chip selects are high outside cycles. Address bits above bit 1 stay constant across all cycles of one request.
- R9: req_ready is high only when the sequencer is idle. A request is accepted on a clock edge where req_valid and req_ready are both high. A req_valid pulse while busy creates no cycle and does not change the running request.
- R10: After reset, req_ready = 1, ext_cs_n is all ones, ext_re_n = 1, ext_we_n = 4'hF, ext_d_oe = 0 and done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address |
| req_blk | input | BLK_W | Chip-select block number |
| req_wdata | input | 32 | Write data in natural byte lanes |
| req_ready | output | 1 | Idle, request can be accepted |
| blk0_narrow | input | 1 | Static: block 0 is 8 bits wide |
| cfg_width | input | NBLK-1 | Bit b: 0 = block b is 8 bits wide |
| cfg_wait | input | NBLK*WAIT_W | Wait count per block |
| ext_addr | output | ADDR_W | External address |
| ext_cs_n | output | NBLK | Active-low chip selects |
| ext_re_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 4 | Active-low per-lane write strobes |
| ext_d_out | output | 32 | Write data lines |
| ext_d_oe | output | 1 | Data lines driven |
| ext_d_in | input | 32 | Read data lines |
| done | output | 1 | Request complete pulse |
| rdata | output | 32 | Assembled read data |

## Verification
The bench builds the block with its default parameters: a 16-bit address, four blocks and 4-bit wait counts. It sets the wait values to 0, 3, 1 and 15, so both the shortest and the longest strobe are reached. Blocks 0, 1 and 3 are configured 8 bits wide and block 2 wide, so every request size runs in both width modes. Block 0 is later switched to wide through its static mode input. The half-word tests use address bit 1 set, and the byte tests use non-zero lanes, so the lane placement and the fixed upper address can both be observed. One request gets an extra valid pulse while the sequencer is busy.

// File: rtl/nbs_pkg.sv
// Package: shared types and helpers for the narrow bus sequencer.
// Assumes: external data path is 32 bits; narrow blocks use lane 0 pins.
package nbs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STRB = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    // Number of external cycles for a request.
    function automatic logic [2:0] beat_count(input logic [1:0] size, input logic narrow);
        if (!narrow)              return 3'd1;
        else if (size == SZ_BYTE) return 3'd1;
        else if (size == SZ_HALF) return 3'd2;
        else                      return 3'd4;
    endfunction

    // Address bits [1:0] of the first external cycle.
    function automatic logic [1:0] first_offset(input logic [1:0] size, input logic [1:0] lo,
                                                input logic narrow);
        if (!narrow || size == SZ_BYTE) return lo;
        else if (size == SZ_HALF)       return {lo[1], 1'b0};
        else                            return 2'b00;
    endfunction

    // Byte lanes touched by a single full-width cycle.
    function automatic logic [3:0] wide_lanes(input logic [1:0] size, input logic [1:0] lo);
        if (size == SZ_BYTE)      return 4'b0001 << lo;
        else if (size == SZ_HALF) return lo[1] ? 4'b1100 : 4'b0011;
        else                      return 4'b1111;
    endfunction

endpackage

// File: rtl/nbs_plan.sv
// Module: nbs_plan
// Decodes a request into the cycle plan: width mode, cycle count, first
// offset, lane mask and wait count of the addressed block.
// Assumes: req_blk is below NBLK; pure combinational.
module nbs_plan
    import nbs_pkg::*;
#(
    parameter int NBLK   = 4,
    parameter int WAIT_W = 4,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [1:0]             size,
    input  logic [1:0]             addr_lo,
    input  logic [BLK_W-1:0]       blk,
    input  logic                   blk0_narrow,
    input  logic [NBLK-1:1]        cfg_width,
    input  logic [NBLK*WAIT_W-1:0] cfg_wait,
    output logic                   narrow,
    output logic [2:0]             nbeats,
    output logic [1:0]             first_off,
    output logic [3:0]             lane_mask,
    output logic [WAIT_W-1:0]      wait_val
);
    logic [NBLK-1:0] wide_vec;

    // Width vector over all blocks, block 0 taken from the static mode input.
    always_comb wide_vec = {cfg_width, ~blk0_narrow};

    // Plan fields for the request at the block's edge.
    always_comb begin
        narrow    = ~wide_vec[blk];
        nbeats    = beat_count(size, narrow);
        first_off = first_offset(size, addr_lo, narrow);
        lane_mask = wide_lanes(size, addr_lo);
        wait_val  = cfg_wait[blk*WAIT_W +: WAIT_W];
    end
endmodule

// File: rtl/nbs_wait_timer.sv
// Module: nbs_wait_timer
// Down-counter that times one strobe: loaded with W, expires after W+1
// clocks of counting.
// Assumes: load is pulsed on the edge that starts a strobe.
module nbs_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expire
);
    logic [WAIT_W-1:0] cnt;

    // Load or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Strobe ends on the clock where the count has reached zero.
    always_comb expire = (cnt == '0);
endmodule

// File: rtl/nbs_gather.sv
// Module: nbs_gather
// Read word assembly: one register per byte lane, written in place by
// narrow cycles or all at once by a wide cycle.
// Assumes: clr and captures are never asserted together.
module nbs_gather (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        cap_byte,
    input  logic [1:0]  lane,
    input  logic        cap_word,
    input  logic [31:0] d_in,
    output logic [31:0] word
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] lane_q;

        // Lane register: cleared per request, filled by its own cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                    lane_q <= '0;
            else if (cap_word)                    lane_q <= d_in[g*8 +: 8];
            else if (cap_byte && lane == 2'(g))   lane_q <= d_in[7:0];
        end

        assign word[g*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/narrow_bus_seq.sv
// Module: narrow_bus_seq (top)
// Accepts one request at a time and runs it as fixed-wait external cycles,
// split into ordered byte cycles for 8-bit blocks.
// Assumes: cfg inputs are stable while a request is running; ext_d_in is
// stable during a read strobe.
module narrow_bus_seq
    import nbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBLK   = 4,
    parameter int WAIT_W = 4,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [1:0]             req_size,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BLK_W-1:0]       req_blk,
    input  logic [31:0]            req_wdata,
    output logic                   req_ready,
    input  logic                   blk0_narrow,
    input  logic [NBLK-1:1]        cfg_width,
    input  logic [NBLK*WAIT_W-1:0] cfg_wait,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic [NBLK-1:0]        ext_cs_n,
    output logic                   ext_re_n,
    output logic [3:0]             ext_we_n,
    output logic [31:0]            ext_d_out,
    output logic                   ext_d_oe,
    input  logic [31:0]            ext_d_in,
    output logic                   done,
    output logic [31:0]            rdata
);
    seq_state_t        state;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        off_q;
    logic [2:0]        left_q;
    logic              write_q;
    logic              narrow_q;
    logic [BLK_W-1:0]  blk_q;
    logic [WAIT_W-1:0] wait_q;
    logic [31:0]       wdata_q;
    logic [3:0]        mask_q;

    logic              p_narrow;
    logic [2:0]        p_beats;
    logic [1:0]        p_off;
    logic [3:0]        p_mask;
    logic [WAIT_W-1:0] p_wait;
    logic              accept;
    logic              stb;
    logic              expire;
    logic              t_load;
    logic [WAIT_W-1:0] t_val;
    logic              beat_end;

    nbs_plan #(.NBLK(NBLK), .WAIT_W(WAIT_W)) plan_i (
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .blk        (req_blk),
        .blk0_narrow(blk0_narrow),
        .cfg_width  (cfg_width),
        .cfg_wait   (cfg_wait),
        .narrow     (p_narrow),
        .nbeats     (p_beats),
        .first_off  (p_off),
        .lane_mask  (p_mask),
        .wait_val   (p_wait)
    );

    // Handshake and strobe-phase decode.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_ready && req_valid;
        stb       = (state == ST_STRB);
        beat_end  = stb && expire;
        t_load    = accept || (state == ST_GAP);
        t_val     = accept ? p_wait : wait_q;
    end

    nbs_wait_timer #(.WAIT_W(WAIT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expire  (expire)
    );

    nbs_gather gather_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .cap_byte(beat_end && !write_q && narrow_q),
        .lane    (off_q),
        .cap_word(beat_end && !write_q && !narrow_q),
        .d_in    (ext_d_in),
        .word    (rdata)
    );

    // Sequencer state: idle -> strobe (-> gap -> strobe)* -> done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) state <= ST_STRB;
                ST_STRB: if (expire) state <= (left_q == 3'd1) ? ST_DONE : ST_GAP;
                ST_GAP:  state <= ST_STRB;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request registers, captured on accept; offset and count step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            off_q    <= '0;
            left_q   <= '0;
            write_q  <= 1'b0;
            narrow_q <= 1'b0;
            blk_q    <= '0;
            wait_q   <= '0;
            wdata_q  <= '0;
            mask_q   <= '0;
        end else if (accept) begin
            base_q   <= req_addr;
            off_q    <= p_off;
            left_q   <= p_beats;
            write_q  <= req_write;
            narrow_q <= p_narrow;
            blk_q    <= req_blk;
            wait_q   <= p_wait;
            wdata_q  <= req_wdata;
            mask_q   <= p_mask;
        end else if (beat_end && left_q != 3'd1) begin
            off_q  <= off_q + 2'd1;
            left_q <= left_q - 3'd1;
        end
    end

    // Address, strobes and write data presented to the external pins.
    always_comb begin
        ext_addr  = narrow_q ? {base_q[ADDR_W-1:2], off_q} : base_q;
        ext_re_n  = !(stb && !write_q);
        ext_we_n  = 4'hF;
        if (stb && write_q) ext_we_n = narrow_q ? 4'b1110 : ~mask_q;
        ext_d_oe  = stb && write_q;
        ext_d_out = narrow_q ? {24'h0, wdata_q[{off_q, 3'b000} +: 8]} : wdata_q;
        done      = (state == ST_DONE);
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_cs
        assign ext_cs_n[g] = !(stb && blk_q == BLK_W'(g));
    end
endmodule

// File: rtl/nbs_checker.sv
// Module: nbs_checker
// Property checks on the sequencer's pins, attached to the top by bind.
// Assumes: cfg_wait is stable while a strobe is running.
module nbs_checker #(
    parameter int ADDR_W = 16,
    parameter int NBLK   = 4,
    parameter int WAIT_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [NBLK*WAIT_W-1:0] cfg_wait,
    input logic [ADDR_W-1:0]      ext_addr,
    input logic [NBLK-1:0]        ext_cs_n,
    input logic                   ext_re_n,
    input logic [3:0]             ext_we_n,
    input logic                   ext_d_oe,
    input logic                   done
);
    logic        stb;
    logic        stb_q;
    logic [15:0] run_len;
    logic [15:0] run_exp;

    // Any strobe active on the pins.
    always_comb stb = !ext_re_n || (ext_we_n != 4'hF);

    // Expected strobe length for the block whose select is low.
    always_comb begin
        run_exp = '0;
        for (int b = 0; b < NBLK; b++)
            if (!ext_cs_n[b]) run_exp = 16'(cfg_wait[b*WAIT_W +: WAIT_W]) + 16'd1;
    end

    // Strobe run-length counter with its end-of-run check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            run_len <= '0;
        end else begin
            stb_q   <= stb;
            run_len <= stb ? run_len + 16'd1 : '0;
            if (stb && run_len != '0 && !$stable(ext_cs_n))
                assert_cs_steady_R8: assert (1'b0) else $error("chip select moved inside a strobe");
            if (!stb && stb_q)
                assert_wait_len_R5: assert (run_len == run_exp_q)
                    else $error("strobe length %0d, expected %0d", run_len, run_exp_q);
        end
    end

    logic [15:0] run_exp_q;

    // Length expected for the strobe in progress, held for the end check.
    always_ff @(posedge clk) begin
        if (!rst_n)   run_exp_q <= '0;
        else if (stb) run_exp_q <= run_exp;
    end

    assert_rw_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_re_n && ext_we_n != 4'hF));
    assert_oe_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_d_oe |-> (ext_re_n && ext_we_n != 4'hF));
    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));
    assert_cs_only_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> (ext_cs_n == '1));
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(ext_addr[ADDR_W-1:2]));
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(stb) && !stb && !req_ready));
    assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));
endmodule

bind narrow_bus_seq nbs_checker #(.ADDR_W(ADDR_W), .NBLK(NBLK), .WAIT_W(WAIT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .cfg_wait (cfg_wait),
    .ext_addr (ext_addr),
    .ext_cs_n (ext_cs_n),
    .ext_re_n (ext_re_n),
    .ext_we_n (ext_we_n),
    .ext_d_oe (ext_d_oe),
    .done     (done)
);

// File: tb/narrow_bus_seq_tb_top.sv
// Scoreboard bench: the driver queues expected external cycles and results,
// and the monitor compares them as the pins move.
module narrow_bus_seq_tb_top;
    localparam int AW = 16;
    localparam int NB = 4;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_blk = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready;
    logic          blk0_narrow = 1'b1;
    logic [NB-1:1] cfg_width = 3'b010;            // block 2 wide, 1 and 3 narrow
    logic [NB*WW-1:0] cfg_wait = {4'd15, 4'd1, 4'd3, 4'd0};
    logic [AW-1:0] ext_addr;
    logic [NB-1:0] ext_cs_n;
    logic          ext_re_n;
    logic [3:0]    ext_we_n;
    logic [31:0]   ext_d_out;
    logic          ext_d_oe;
    logic [31:0]   ext_d_in;
    logic          done;
    logic [31:0]   rdata;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [NB-1:0] cs_n;
        logic          re_n;
        logic [3:0]    we_n;
        logic          oe;
        logic [31:0]   d;
        int            len;
        string         tag;
    } beat_t;

    typedef struct {
        logic        is_read;
        logic [31:0] data;
        string       tag;
    } res_t;

    beat_t beat_q[$];
    res_t  res_q[$];

    always #5 clk = ~clk;

    narrow_bus_seq dut_i (.*);

    // Memory model answering reads from the current address.
    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8], ~a[7:0], a[7:0] ^ a[15:8] ^ 8'hA5};
    endfunction
    assign ext_d_in = mem_word(ext_addr);

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each external cycle and each completion with the queues.
    logic  stb_prev = 1'b0;
    int    run = 0;
    beat_t cur;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic stb = !ext_re_n || ext_we_n != 4'hF;
            if (stb && !stb_prev) begin
                if (beat_q.size() == 0) begin
                    check(1'b0, "R9 unexpected external cycle", {16'h0, ext_addr}, 32'h0);
                    cur.len = 0; cur.tag = "R9";
                end else begin
                    cur = beat_q.pop_front();
                    check(ext_addr == cur.addr, {cur.tag, " address"}, {16'h0, ext_addr}, {16'h0, cur.addr});
                    check(ext_cs_n == cur.cs_n, "R8 chip select", {28'h0, ext_cs_n}, {28'h0, cur.cs_n});
                    check(ext_re_n == cur.re_n && ext_we_n == cur.we_n, "R7 strobes",
                          {27'h0, ext_re_n, ext_we_n}, {27'h0, cur.re_n, cur.we_n});
                    check(ext_d_oe == cur.oe, "R7 data drive", {31'h0, ext_d_oe}, {31'h0, cur.oe});
                    if (cur.oe)
                        check(ext_d_out == cur.d, {cur.tag, " write data"}, ext_d_out, cur.d);
                end
                run = 1;
            end else if (stb) begin
                run++;
            end
            if (!stb && stb_prev && cur.len != 0)
                check(run == cur.len, "R5 strobe length", run, cur.len);
            if (done) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", 32'h0, 32'h0);
                end else begin
                    automatic res_t r = res_q.pop_front();
                    if (r.is_read) check(rdata == r.data, {r.tag, " read data"}, rdata, r.data);
                end
            end
            stb_prev = stb;
        end
    end

    // Driver: queue expectations, issue one request, time its completion.
    task automatic do_req(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [1:0] b, input logic [31:0] wd, input string tag,
                          input bit intrude = 1'b0);
        bit narrow;
        int nb;
        int w;
        logic [1:0] off;
        logic [31:0] exp_rd;
        int k;
        narrow = (b == 0) ? blk0_narrow : !cfg_width[b];
        w      = int'(cfg_wait[b*WW +: WW]);
        exp_rd = 32'h0;
        if (narrow) begin
            nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            off = (sz == 2'd0) ? a[1:0] : (sz == 2'd1) ? {a[1], 1'b0} : 2'b00;
            for (int i = 0; i < nb; i++) begin
                automatic beat_t e;
                automatic logic [1:0] o = off + 2'(i);
                e.addr = {a[AW-1:2], o};
                e.cs_n = ~(4'b0001 << b);
                e.re_n = wr;
                e.we_n = wr ? 4'b1110 : 4'hF;
                e.oe   = wr;
                e.d    = {24'h0, wd[o*8 +: 8]};
                e.len  = w + 1;
                e.tag  = tag;
                beat_q.push_back(e);
                exp_rd[o*8 +: 8] = mem_word(e.addr)[7:0];
            end
        end else begin
            automatic beat_t e;
            automatic logic [3:0] m = (sz == 2'd0) ? (4'b0001 << a[1:0]) :
                                      (sz == 2'd1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
            nb = 1;
            e.addr = a;
            e.cs_n = ~(4'b0001 << b);
            e.re_n = wr;
            e.we_n = wr ? ~m : 4'hF;
            e.oe   = wr;
            e.d    = wd;
            e.len  = w + 1;
            e.tag  = tag;
            beat_q.push_back(e);
            exp_rd = mem_word(a);
        end
        res_q.push_back('{is_read: !wr, data: exp_rd, tag: tag});

        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_blk = b; req_wdata = wd;
        @(posedge clk);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            req_valid = 1'b0;
            if (intrude && k == 2) begin
                check(req_ready == 1'b0, "R9 ready low while busy", {31'h0, req_ready}, 32'h0);
                req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2;
                req_addr = 16'h0F00; req_blk = 2'd1; req_wdata = 32'hDEADBEEF;
            end
        end while (!done && k < 2000);
        req_valid = 1'b0;
        check(k == nb * (w + 2), "R6 completion latency", k, nb * (w + 2));
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R6 done single pulse then idle",
              {30'h0, done, req_ready}, 32'h1);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after reset", {31'h0, req_ready}, 32'h1);
        check(ext_cs_n == 4'hF && ext_re_n && ext_we_n == 4'hF, "R10 strobes idle",
              {23'h0, ext_cs_n, ext_re_n, ext_we_n}, {23'h0, 4'hF, 1'b1, 4'hF});
        check(!ext_d_oe && !done, "R10 oe and done low", {30'h0, ext_d_oe, done}, 32'h0);

        // R1: byte requests on narrow block 1 (wait 3)
        do_req(1'b1, 2'd0, 16'h1236, 2'd1, 32'hA1B2C3D4, "R1 byte write");
        do_req(1'b0, 2'd0, 16'h1237, 2'd1, 32'h0, "R1 byte read");
        // R2: half-words with address bit 1 set, narrow block 3 (wait 15)
        do_req(1'b1, 2'd1, 16'h4562, 2'd3, 32'h11223344, "R2 half write");
        do_req(1'b0, 2'd1, 16'h4563, 2'd3, 32'h0, "R2 half read");
        // R3: words on narrow block 0 (wait 0)
        do_req(1'b1, 2'd2, 16'h7A0C, 2'd0, 32'hCAFEF00D, "R3 word write");
        do_req(1'b0, 2'd2, 16'h7A0E, 2'd0, 32'h0, "R3 word read");
        // R4: wide block 2 (wait 1), all sizes
        do_req(1'b1, 2'd0, 16'h0103, 2'd2, 32'h55667788, "R4 wide byte write");
        do_req(1'b1, 2'd1, 16'h0102, 2'd2, 32'h99AABBCC, "R4 wide half write");
        do_req(1'b1, 2'd3, 16'h0100, 2'd2, 32'h0BADC0DE, "R4 wide word write");
        do_req(1'b0, 2'd2, 16'h2468, 2'd2, 32'h0, "R4 wide word read");
        // R4: block 0 switched wide through its static mode input
        blk0_narrow = 1'b0;
        @(negedge clk);
        do_req(1'b0, 2'd2, 16'h3C3C, 2'd0, 32'h0, "R4 block0 wide read");
        do_req(1'b1, 2'd1, 16'h3C3E, 2'd0, 32'h12345678, "R4 block0 wide half write");
        blk0_narrow = 1'b1;
        @(negedge clk);
        // R9: valid pulse while busy must be ignored
        do_req(1'b0, 2'd2, 16'h5550, 2'd1, 32'h0, "R9 word read with intrusion", 1'b1);
        repeat (20) @(negedge clk);
        check(beat_q.size() == 0 && res_q.size() == 0, "R9 no leftover or extra traffic",
              beat_q.size() + res_q.size(), 0);
        check(req_ready == 1'b1 && ext_cs_n == 4'hF, "R9 idle at end",
              {27'h0, req_ready, ext_cs_n}, {27'h0, 1'b1, 4'hF});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule